// File: doc/BRIEF.md
# Calendar Alarm Field Comparator

This block watches a calendar that is kept elsewhere and raises an alarm when that calendar reaches a programmed moment. The calendar arrives as seven BCD fields: seconds, minutes, hours, weekday, day of month, month and year. A strobe marks each cycle in which those fields hold a freshly updated value. Software programs one alarm register per field. Each register carries its own enable flag, so an alarm can be as narrow as one exact instant or as loose as "whenever the minutes read 30".

Alarm writes go into staging registers. They do not touch the comparison until a separate commit write copies all seven staged fields into the active set at once. This keeps a half-written alarm from ever matching. A match sets a sticky status flag, which software clears by writing one to it. The interrupt line is the status flag gated by an interrupt-enable bit.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset the status flag, the interrupt enable, the interrupt output and all active and staged field enables are 0.
- R2: Write addresses 0 to 6 stage seconds, minutes, hours, weekday, day of month, month and year, in that order. The BCD value sits in data bits [6:0], [6:0], [5:0], [2:0], [5:0], [4:0] and [7:0] respectively, and data bit 15 is that field's compare enable. The year is the two-digit BCD count from 1970 and is compared exactly as the calendar presents it.
- R3: A field whose active enable is 0 takes no part in the match, whatever its value.
- R4: Staged values affect nothing until a write to address 7 with data bit 15 set copies all seven staged fields into the active set. A write to address 7 with bit 15 clear changes nothing.
- R5: A match is judged only in a cycle with the calendar strobe high. The status flag rises on the clock edge that samples that strobe, and calendar values held without a strobe never set it.
- R6: When no active field is enabled, no strobe sets the status flag.
- R7: The status flag stays set until a write to address 9 with data bit 0 set. A write to address 9 with bit 0 clear leaves it unchanged.
- R8: If a match and a clearing write to address 9 land in the same cycle, the status flag ends up set.
- R9: The interrupt output equals the status flag AND the interrupt enable. The enable is written through bit 0 of address 8, and the output follows from the edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_tick | input | 1 | High for one cycle when the calendar fields hold a new value |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD, 24-hour |
| cal_wday | input | 3 | Calendar weekday |
| cal_mday | input | 6 | Calendar day of month, BCD |
| cal_mon | input | 5 | Calendar month, BCD |
| cal_year | input | 8 | Calendar year since 1970, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| alarm_status | output | 1 | Sticky match flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The bench targets a calendar that keeps a matching value for many cycles without a strobe. A design that compared on every cycle would set the status there, and it would also re-arm the interrupt right after software cleared it. The bench fires strobes while no field is enabled, which catches an AND-reduce that reports true on an empty set. It exercises staged-but-uncommitted values and a commit write with the trigger bit clear, so a design that bypassed staging would match too early. It also places a clearing write in the same cycle as a match, where a design that gave the clear priority would lose an alarm.

// File: rtl/cam_pkg.sv
// Package: shared constants for the calendar alarm comparator.
// Field order, widths and register addresses are fixed here.
package cam_pkg;
    localparam int unsigned NUM_FIELDS = 7;
    localparam int unsigned DATA_W     = 16;
    localparam int unsigned ADDR_W     = 4;
    localparam int unsigned EN_BIT     = 15;
    // seconds, minutes, hours, weekday, mday, month, year
    localparam int unsigned FIELD_W [NUM_FIELDS] = '{7, 7, 6, 3, 6, 5, 8};

    localparam logic [ADDR_W-1:0] ADDR_COMMIT = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_IRQEN  = 4'd8;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd9;

    // Bit offset of field i inside the packed calendar vector.
    function automatic int unsigned field_off(input int unsigned i);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < i; k++) acc += FIELD_W[k];
        return acc;
    endfunction

    localparam int unsigned CAL_W = field_off(NUM_FIELDS);
endpackage

// File: rtl/cam_field.sv
// Module: one alarm field. It holds a staged value and enable, and
// copies them into the active set on commit.
// Assumes stage_we and commit are never high in the same cycle.
module cam_field #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stage_we,
    input  logic [W-1:0] stage_val,
    input  logic         stage_en,
    input  logic         commit,
    input  logic [W-1:0] cal_val,
    output logic         act_en,
    output logic         eq
);
    logic [W-1:0] stg_val_q;
    logic         stg_en_q;
    logic [W-1:0] act_val_q;

    // Staging register: loaded by a field write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_val_q <= '0;
            stg_en_q  <= 1'b0;
        end else if (stage_we) begin
            stg_val_q <= stage_val;
            stg_en_q  <= stage_en;
        end
    end

    // Active register: copied from staging on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_val_q <= '0;
            act_en    <= 1'b0;
        end else if (commit) begin
            act_val_q <= stg_val_q;
            act_en    <= stg_en_q;
        end
    end

    // Equality of the active value with the live calendar field.
    always_comb eq = (act_val_q == cal_val);
endmodule

// File: rtl/cam_combine.sv
// Module: reduces per-field results to one match pulse.
// A match needs a strobe, at least one enabled field, and every
// enabled field equal.
module cam_combine #(
    parameter int unsigned N = 7
) (
    input  logic         cal_tick,
    input  logic [N-1:0] en_vec,
    input  logic [N-1:0] eq_vec,
    output logic         fire
);
    logic any_en;
    logic all_ok;

    // Match decision for this cycle.
    always_comb begin
        any_en = |en_vec;
        all_ok = &(~en_vec | eq_vec);
        fire   = cal_tick && any_en && all_ok;
    end
endmodule

// File: rtl/cam_irq_ctrl.sv
// Module: sticky status flag with write-one-to-clear, interrupt
// enable bit and the gated interrupt output. A set beats a clear.
module cam_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr_wr,
    input  logic ie_wr,
    input  logic ie_val,
    output logic status,
    output logic irq
);
    logic ie_q;

    // Sticky status: set on match, cleared by a one-write.
    always_ff @(posedge clk) begin
        if (!rst_n)       status <= 1'b0;
        else if (fire)    status <= 1'b1;
        else if (clr_wr)  status <= 1'b0;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (ie_wr)  ie_q <= ie_val;
    end

    // Interrupt output is status gated by enable.
    always_comb irq = status && ie_q;
endmodule

// File: rtl/cal_alarm_match.sv
// Module: calendar alarm comparator top. It decodes register writes,
// holds seven per-field alarm slices, and drives status and interrupt.
// Assumes the calendar fields are stable whenever cal_tick is high.
module cal_alarm_match
    import cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_tick,
    input  logic [6:0]        cal_sec,
    input  logic [6:0]        cal_min,
    input  logic [5:0]        cal_hour,
    input  logic [2:0]        cal_wday,
    input  logic [5:0]        cal_mday,
    input  logic [4:0]        cal_mon,
    input  logic [7:0]        cal_year,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              alarm_status,
    output logic              alarm_irq
);
    logic [CAL_W-1:0]      cal_vec;
    logic [NUM_FIELDS-1:0] act_en;
    logic [NUM_FIELDS-1:0] eq_vec;
    logic                  commit;
    logic                  fire;
    logic                  clr_wr;
    logic                  ie_wr;

    // Pack calendar fields, seconds at bit 0.
    always_comb cal_vec = {cal_year, cal_mon, cal_mday, cal_wday,
                           cal_hour, cal_min, cal_sec};

    // Decode the control writes.
    always_comb begin
        commit = wr_en && (wr_addr == ADDR_COMMIT) && wr_data[EN_BIT];
        clr_wr = wr_en && (wr_addr == ADDR_STATUS) && wr_data[0];
        ie_wr  = wr_en && (wr_addr == ADDR_IRQEN);
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam int unsigned W   = FIELD_W[g];
        localparam int unsigned OFF = field_off(g);
        logic stage_we;

        // Write strobe for this field's staging register.
        always_comb stage_we = wr_en && (wr_addr == ADDR_W'(g));

        cam_field #(.W(W)) u_field (
            .clk       (clk),
            .rst_n     (rst_n),
            .stage_we  (stage_we),
            .stage_val (wr_data[W-1:0]),
            .stage_en  (wr_data[EN_BIT]),
            .commit    (commit),
            .cal_val   (cal_vec[OFF +: W]),
            .act_en    (act_en[g]),
            .eq        (eq_vec[g])
        );
    end

    cam_combine #(.N(NUM_FIELDS)) u_comb (
        .cal_tick (cal_tick),
        .en_vec   (act_en),
        .eq_vec   (eq_vec),
        .fire     (fire)
    );

    cam_irq_ctrl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .clr_wr (clr_wr),
        .ie_wr  (ie_wr),
        .ie_val (wr_data[0]),
        .status (alarm_status),
        .irq    (alarm_irq)
    );
endmodule

// File: rtl/cam_checker.sv
// Module: temporal checks on the alarm comparator, bound to the top.
module cam_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cal_tick,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic [6:0]  act_en,
    input logic        alarm_status,
    input logic        alarm_irq
);
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_status) |-> $past(cal_tick));                        // R5
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_status && !(wr_en && wr_addr == 4'd9 && wr_data[0])
        |=> alarm_status);                                              // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == 4'd9 && wr_data[0] && !cal_tick
        |=> !alarm_status);                                             // R7
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_status);                                    // R9
    AST_NO_FIELDS_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_tick && act_en == 7'd0 && !alarm_status |=> !alarm_status); // R6
endmodule

bind cal_alarm_match cam_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cal_tick     (cal_tick),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .act_en       (act_en),
    .alarm_status (alarm_status),
    .alarm_irq    (alarm_irq)
);

// File: tb/tb_cal_alarm_match.sv
module tb_cal_alarm_match;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cal_tick = 0;
    logic [6:0]  cal_sec = 0, cal_min = 0;
    logic [5:0]  cal_hour = 0, cal_mday = 0;
    logic [2:0]  cal_wday = 0;
    logic [4:0]  cal_mon = 0;
    logic [7:0]  cal_year = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic        alarm_status, alarm_irq;

    int total = 0, bad = 0;
    bit done = 0;

    // Reference model state
    int stg_v [7], stg_e [7], act_v [7], act_e [7];
    int m_status = 0, m_ie = 0;
    int fw [7] = '{7, 7, 6, 3, 6, 5, 8};

    always #5 clk = ~clk;

    cal_alarm_match dut (.*);

    function automatic int calv(int i);
        case (i)
            0: return cal_sec;   1: return cal_min;  2: return cal_hour;
            3: return cal_wday;  4: return cal_mday; 5: return cal_mon;
            default: return cal_year;
        endcase
    endfunction

    // Behavioural model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) begin
                stg_v[i] = 0; stg_e[i] = 0; act_v[i] = 0; act_e[i] = 0;
            end
            m_status = 0; m_ie = 0;
        end else begin
            int any, ok, fire;
            any = 0; ok = 1;
            for (int i = 0; i < 7; i++)
                if (act_e[i] != 0) begin
                    any = 1;
                    if (act_v[i] != calv(i)) ok = 0;
                end
            fire = (cal_tick && any && ok) ? 1 : 0;
            if (fire) m_status = 1;
            else if (wr_en && wr_addr == 9 && wr_data[0]) m_status = 0;
            if (wr_en && wr_addr == 8) m_ie = wr_data[0];
            if (wr_en && wr_addr == 7 && wr_data[15])
                for (int i = 0; i < 7; i++) begin
                    act_v[i] = stg_v[i]; act_e[i] = stg_e[i];
                end
            if (wr_en && wr_addr < 7) begin
                stg_v[wr_addr] = wr_data & ((1 << fw[wr_addr]) - 1);
                stg_e[wr_addr] = wr_data[15];
            end
        end
    end

    // Per-clock comparison against the model (R9 gating included).
    always @(negedge clk) if (rst_n && !done) begin
        total++;
        if (alarm_status !== m_status[0] || alarm_irq !== (m_status[0] & m_ie[0])) begin
            bad++;
            $display("FAIL R9 model compare: status=%0b irq=%0b expected status=%0b irq=%0b",
                     alarm_status, alarm_irq, m_status[0], m_status[0] & m_ie[0]);
        end
    end

    task automatic chk(string req, logic st, logic irq);
        total++;
        if (alarm_status !== st || alarm_irq !== irq) begin
            bad++;
            $display("FAIL %s: status=%0b irq=%0b expected status=%0b irq=%0b",
                     req, alarm_status, alarm_irq, st, irq);
        end
    endtask

    task automatic wr(int a, int d);
        wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic tick();
        cal_tick = 1;
        @(negedge clk);
        cal_tick = 0;
    endtask

    task automatic set_cal(int s, int mi, int h, int wd, int md, int mo, int y);
        cal_sec = 7'(s); cal_min = 7'(mi); cal_hour = 6'(h); cal_wday = 3'(wd);
        cal_mday = 6'(md); cal_mon = 5'(mo); cal_year = 8'(y);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset", 0, 0);
        // R6: a strobe with nothing committed never fires
        set_cal(0, 0, 0, 0, 0, 0, 0);
        tick();
        chk("R6 no fields after reset", 0, 0);

        // R4: staged but not committed
        wr(0, 16'h8030); wr(1, 16'h8015);
        set_cal('h30, 'h15, 'h07, 2, 'h11, 'h04, 'h55);
        tick();
        chk("R4 staged only", 0, 0);
        wr(7, 16'h0000);
        tick();
        chk("R4 commit bit clear", 0, 0);
        wr(7, 16'h8000);
        // R5: hold match without strobe
        repeat (5) @(negedge clk);
        chk("R5 no strobe", 0, 0);
        cal_sec = 7'h31;
        tick();
        chk("R5 mismatch", 0, 0);
        // R3: hour/day differ, not enabled
        cal_sec = 7'h30; cal_hour = 6'h12;
        tick();
        chk("R3 disabled fields ignored", 1, 0);
        // R9
        wr(8, 1);
        chk("R9 irq enabled", 1, 1);
        wr(8, 0);
        chk("R9 irq gated", 1, 0);
        wr(8, 1);
        // R7
        wr(9, 0);
        chk("R7 zero write keeps", 1, 1);
        repeat (4) @(negedge clk);
        chk("R7 sticky", 1, 1);
        wr(9, 1);
        chk("R7 cleared", 0, 0);
        repeat (4) @(negedge clk);
        chk("R5 no re-fire without strobe", 0, 0);
        // R8: clear and match together
        cal_tick = 1; wr(9, 1); cal_tick = 0;
        chk("R8 set wins", 1, 1);
        wr(9, 1);
        chk("R7 clear again", 0, 0);

        // R2: all seven fields
        wr(0, 16'h8059); wr(1, 16'h8059); wr(2, 16'h8023); wr(3, 16'h8006);
        wr(4, 16'h8031); wr(5, 16'h8012); wr(6, 16'h8099); wr(7, 16'h8000);
        set_cal('h59, 'h59, 'h23, 5, 'h31, 'h12, 'h99);
        tick();
        chk("R2 weekday mismatch", 0, 0);
        cal_wday = 3'd6; cal_year = 8'h98;
        tick();
        chk("R2 year mismatch", 0, 0);
        cal_year = 8'h99;
        tick();
        chk("R2 full match", 1, 1);
        wr(9, 1);
        chk("R7 clear full", 0, 0);

        // R6: all disabled
        for (int i = 0; i < 7; i++) wr(i, 16'h0000);
        wr(7, 16'h8000);
        tick(); tick();
        chk("R6 all disabled", 0, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: expired, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule